// File: doc/BRIEF.md
# Memory ECC Error Log Controller

This block sits next to a 64-bit on-chip memory whose ECC checker reports single-bit (correctable) and multi-bit (uncorrectable) events. For each of the two error classes it raises a sticky status flag and records the address offset and the 64-bit data of the first failing access. It keeps that record until software acknowledges the flag by writing one to it. A mask register, driven through separate unmask and mask-set write ports, decides which flags reach the single interrupt line.

The block also drives a fault-injection path for the memory's write port. Software loads a 64-bit flip pattern into two 32-bit words, low word first, and a 24-bit countdown. Each memory write with a nonzero count decrements the count. The first write that finds the count at zero has the pattern XORed into its data and check bits. The pattern then clears itself, so the injection happens only once. A single set bit produces a correctable test error and two distinct set bits produce an uncorrectable one. All registers sit on a plain 32-bit write/read port with combinational read data. Software forms the full failing address by ORing the logged offset with the memory window base 0xFFFC0000.

Top module: `ecc_err_log`

## Requirements
- R1: Bit 0 of the control register (offset 0x00) is read/write, resets to 1 and drives `ecc_en`. The other bits read 0.
- R2: The status register (offset 0x04) shows the correctable flag in bit 6 and the uncorrectable flag in bit 7. An event sets its flag whether or not it is masked. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. The other bits read 0.
- R3: When an event and a write-one-to-clear of its flag fall in the same cycle, the flag stays set and the log takes the new event.
- R4: While a flag is set, further events of that class leave its log unchanged. After the flag is cleared, the next event is captured.
- R5: A correctable and an uncorrectable event in the same cycle set both flags, and each class's log captures the access.
- R6: The mask register (offset 0x08, bits 6 and 7, 1 = masked) resets to 0xC0. Writing 1s to offset 0x0C unmasks the matching bits. Writing 1s to offset 0x10 masks them. Other data bits have no effect.
- R7: `irq` is high exactly when some flag is set and its mask bit is 0.
- R8: The correctable log (address offset at 0x14, data low at 0x18, data high at 0x1C) and the uncorrectable log (0x20, 0x24, 0x28) read back the captured offset, zero-extended, and the 64-bit data split into a low and a high word.
- R9: The injection pattern words (low at 0x2C, high at 0x30) are read/write. The count register (0x34) keeps only data bits 23:0, and its upper bits read 0.
- R10: A memory write with a nonzero count decrements the count and is not flipped. A memory write that finds the count at 0 and the pattern nonzero puts the 64-bit pattern ({high,low}) on `inj_flip` in that same cycle. Both pattern words then read 0, so later writes are not flipped.
- R11: `inj_flip` is 0 in every cycle without a memory write, even when an injection is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ecc_en | output | 1 | ECC checker enable |
| ce_evt | input | 1 | Correctable error event from the checker |
| ue_evt | input | 1 | Uncorrectable error event from the checker |
| evt_addr | input | AW (18) | Address offset of the failing access |
| evt_data | input | 64 | Data of the failing access |
| mem_wr | input | 1 | Memory write occurring this cycle |
| inj_flip | output | 64 | Bit-flip mask for this write's data and check bits |
| irq | output | 1 | Interrupt request |

## Verification
The main collision is a new error event in the same cycle as software's write-one-to-clear of that class's flag. The bench provokes it by driving the event strobe and the status write on the same falling edge. The result is judged from the status register, the interrupt and the three log words read back afterwards, which must show the new access with the flag still set. A correctable and an uncorrectable event in one cycle are driven the same way. Random sequences also mix both collisions with mask changes, and every step is compared against a bench model of flags, logs and mask.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_STAT    = 8'h04;
  localparam logic [7:0] OFS_MASK    = 8'h08;
  localparam logic [7:0] OFS_UNMASK  = 8'h0C;
  localparam logic [7:0] OFS_MASKSET = 8'h10;
  localparam logic [7:0] OFS_CE_ADR  = 8'h14;
  localparam logic [7:0] OFS_CE_DLO  = 8'h18;
  localparam logic [7:0] OFS_CE_DHI  = 8'h1C;
  localparam logic [7:0] OFS_UE_ADR  = 8'h20;
  localparam logic [7:0] OFS_UE_DLO  = 8'h24;
  localparam logic [7:0] OFS_UE_DHI  = 8'h28;
  localparam logic [7:0] OFS_INJ_LO  = 8'h2C;
  localparam logic [7:0] OFS_INJ_HI  = 8'h30;
  localparam logic [7:0] OFS_INJ_CNT = 8'h34;
  localparam int CE_BIT = 6;   // status and mask bit of the correctable class
  localparam int UE_BIT = 7;   // status and mask bit of the uncorrectable class
  localparam int NCLS   = 2;   // class 0 = correctable, class 1 = uncorrectable
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int AW = 18,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          flag_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  logic          take;
  logic          flag_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;

  always_comb begin
    take   = evt && (!flag_q || clr);
    flag_d = evt || (flag_q && !clr);
    addr_d = addr_q;
    data_d = data_q;
    if (take) begin
      addr_d = addr;
      data_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (take) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R2
  AST_EVT_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> (flag_q && addr_q == $past(addr) && data_q == $past(data))); // R3
  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> ($stable(addr_q) && $stable(data_q))); // R4
endmodule

// File: rtl/ecc_log_irq.sv
module ecc_log_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic         unmask_we,
  input  logic         maskset_we,
  input  logic [N-1:0] bits,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = unmask_we || maskset_we;
    mask_d  = mask_q;
    if (unmask_we)  mask_d = mask_q & ~bits;
    if (maskset_we) mask_d = mask_q | bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign irq = |(flags & ~mask_q);

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq); // R7
  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_we && !maskset_we) |=> ((mask_q & $past(bits)) == '0)); // R6
endmodule

// File: rtl/ecc_log_inject.sv
module ecc_log_inject #(
  parameter int RW = 32,
  parameter int CW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic            cnt_we,
  input  logic [RW-1:0]   wdata,
  input  logic            mem_wr,
  output logic [2*RW-1:0] pat_q,
  output logic [CW-1:0]   cnt_q,
  output logic [2*RW-1:0] flip
);
  localparam int DW = 2 * RW;

  logic          fire;
  logic [DW-1:0] pat_d;
  logic [CW-1:0] cnt_d;
  logic          pat_en;
  logic          cnt_en;

  always_comb begin
    fire   = mem_wr && (cnt_q == '0) && (|pat_q);
    pat_d  = pat_q;
    if (fire)  pat_d = '0;
    if (lo_we) pat_d[RW-1:0]  = wdata;
    if (hi_we) pat_d[DW-1:RW] = wdata;
    pat_en = fire || lo_we || hi_we;
    cnt_en = cnt_we || (mem_wr && cnt_q != '0);
    cnt_d  = cnt_we ? wdata[CW-1:0] : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      cnt_q <= '0;
    end else begin
      if (pat_en) pat_q <= pat_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign flip = fire ? pat_q : '0;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flip) && !lo_we && !hi_we) |=> (pat_q == '0)); // R10
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cnt_q != '0 && !cnt_we) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
  AST_NO_FLIP_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (flip == '0)); // R10
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int  AW         = 18,
  parameter int  RW         = 32,
  parameter int  CW         = 24,
  parameter bit  ECC_EN_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_we,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  output logic            ecc_en,
  input  logic            ce_evt,
  input  logic            ue_evt,
  input  logic [AW-1:0]   evt_addr,
  input  logic [2*RW-1:0] evt_data,
  input  logic            mem_wr,
  output logic [2*RW-1:0] inj_flip,
  output logic            irq
);
  localparam int DW = 2 * RW;

  logic            en_q;
  logic            en_d;
  logic            ctrl_we;
  logic            stat_we;
  logic [NCLS-1:0] evt_v;
  logic [NCLS-1:0] clr_v;
  logic [NCLS-1:0] flag_v;
  logic [NCLS-1:0] mask_v;
  logic [AW-1:0]   lg_a [NCLS];
  logic [DW-1:0]   lg_d [NCLS];
  logic [DW-1:0]   pat;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   stat_word;
  logic [RW-1:0]   mask_word;

  assign ctrl_we = reg_we && reg_addr == OFS_CTRL;
  assign stat_we = reg_we && reg_addr == OFS_STAT;
  assign evt_v   = {ue_evt, ce_evt};
  assign clr_v   = stat_we ? reg_wdata[UE_BIT:CE_BIT] : '0;
  assign en_d    = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= ECC_EN_RST;
    else if (ctrl_we) en_q <= en_d;
  end
  assign ecc_en = en_q;

  for (genvar gi = 0; gi < NCLS; gi++) begin : g_cls
    ecc_log_capture #(.AW(AW), .DW(DW)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_v[gi]),
      .clr    (clr_v[gi]),
      .addr   (evt_addr),
      .data   (evt_data),
      .flag_q (flag_v[gi]),
      .addr_q (lg_a[gi]),
      .data_q (lg_d[gi])
    );
  end

  ecc_log_irq #(.N(NCLS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flag_v),
    .unmask_we  (reg_we && reg_addr == OFS_UNMASK),
    .maskset_we (reg_we && reg_addr == OFS_MASKSET),
    .bits       (reg_wdata[UE_BIT:CE_BIT]),
    .mask_q     (mask_v),
    .irq        (irq)
  );

  ecc_log_inject #(.RW(RW), .CW(CW)) u_inj (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_we  (reg_we && reg_addr == OFS_INJ_LO),
    .hi_we  (reg_we && reg_addr == OFS_INJ_HI),
    .cnt_we (reg_we && reg_addr == OFS_INJ_CNT),
    .wdata  (reg_wdata),
    .mem_wr (mem_wr),
    .pat_q  (pat),
    .cnt_q  (cnt),
    .flip   (inj_flip)
  );

  always_comb begin
    stat_word = '0;
    mask_word = '0;
    stat_word[UE_BIT:CE_BIT] = flag_v;
    mask_word[UE_BIT:CE_BIT] = mask_v;
    case (reg_addr)
      OFS_CTRL:    reg_rdata = {{(RW-1){1'b0}}, en_q};
      OFS_STAT:    reg_rdata = stat_word;
      OFS_MASK:    reg_rdata = mask_word;
      OFS_CE_ADR:  reg_rdata = {{(RW-AW){1'b0}}, lg_a[0]};
      OFS_CE_DLO:  reg_rdata = lg_d[0][RW-1:0];
      OFS_CE_DHI:  reg_rdata = lg_d[0][DW-1:RW];
      OFS_UE_ADR:  reg_rdata = {{(RW-AW){1'b0}}, lg_a[1]};
      OFS_UE_DLO:  reg_rdata = lg_d[1][RW-1:0];
      OFS_UE_DHI:  reg_rdata = lg_d[1][DW-1:RW];
      OFS_INJ_LO:  reg_rdata = pat[RW-1:0];
      OFS_INJ_HI:  reg_rdata = pat[DW-1:RW];
      OFS_INJ_CNT: reg_rdata = {{(RW-CW){1'b0}}, cnt};
      default:     reg_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flag_v)); // R7
  AST_BOTH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && ue_evt) |=> (&flag_v)); // R5
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ecc_en == $past(reg_wdata[0]))); // R1
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ecc_en;
  logic        ce_evt;
  logic        ue_evt;
  logic [AW-1:0] evt_addr;
  logic [63:0] evt_data;
  logic        mem_wr;
  logic [63:0] inj_flip;
  logic        irq;

  ecc_err_log #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ecc_en(ecc_en),
    .ce_evt(ce_evt), .ue_evt(ue_evt), .evt_addr(evt_addr), .evt_data(evt_data),
    .mem_wr(mem_wr), .inj_flip(inj_flip), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // bench model: index 0 = correctable, 1 = uncorrectable
  logic [1:0]    m_flag;
  logic [1:0]    m_mask;
  logic [AW-1:0] m_addr [2];
  logic [63:0]   m_data [2];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic void model_evt(logic [1:0] ev, logic [1:0] clr,
                                    logic [AW-1:0] a, logic [63:0] d);
    for (int i = 0; i < 2; i++) begin
      if (ev[i] && (!m_flag[i] || clr[i])) begin
        m_addr[i] = a;
        m_data[i] = d;
      end
      m_flag[i] = ev[i] | (m_flag[i] & ~clr[i]);
    end
  endfunction

  // events and optional status clear in the same cycle
  task automatic evt(logic [1:0] ev, logic do_clr, logic [31:0] clrv,
                     logic [AW-1:0] a, logic [63:0] d);
    @(negedge clk);
    ce_evt = ev[0]; ue_evt = ev[1]; evt_addr = a; evt_data = d;
    if (do_clr) begin
      reg_addr = 8'h04; reg_we = 1'b1; reg_wdata = clrv;
    end
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; reg_we = 1'b0;
    model_evt(ev, do_clr ? clrv[7:6] : 2'b00, a, d);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(8'h04, d); chk({"R2 status ", tag}, d, {24'b0, m_flag, 6'b0});
    rd(8'h08, d); chk({"R6 mask ", tag}, d, {24'b0, m_mask, 6'b0});
    chk({"R7 irq ", tag}, irq, |(m_flag & ~m_mask));
    rd(8'h14, d); chk({"R8 ce addr ", tag}, d, {14'b0, m_addr[0]});
    rd(8'h18, d); chk({"R8 ce dlo ", tag}, d, m_data[0][31:0]);
    rd(8'h1C, d); chk({"R4 ce dhi ", tag}, d, m_data[0][63:32]);
    rd(8'h20, d); chk({"R8 ue addr ", tag}, d, {14'b0, m_addr[1]});
    rd(8'h24, d); chk({"R8 ue dlo ", tag}, d, m_data[1][31:0]);
    rd(8'h28, d); chk({"R4 ue dhi ", tag}, d, m_data[1][63:32]);
  endtask

  task automatic memw(output logic [63:0] f);
    @(negedge clk);
    mem_wr = 1'b1;
    #1;
    f = inj_flip;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] f;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    ce_evt = 1'b0; ue_evt = 1'b0; evt_addr = '0; evt_data = '0; mem_wr = 1'b0;
    m_flag = 2'b00; m_mask = 2'b11;
    m_addr[0] = '0; m_addr[1] = '0; m_data[0] = '0; m_data[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(8'h00, d); chk("R1 ctrl reset", d, 32'h1);
    chk("R1 ecc_en reset", ecc_en, 1'b1);
    chk("R11 no flip idle", inj_flip, 64'h0);
    check_all("reset");

    // control bit
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, d); chk("R1 ctrl cleared", d, 32'h0);
    chk("R1 ecc_en low", ecc_en, 1'b0);
    wr(8'h00, 32'h0000_0001);
    chk("R1 ecc_en high", ecc_en, 1'b1);

    // correctable event while masked
    evt(2'b01, 1'b0, 32'h0, 18'h00123, 64'h1111_2222_3333_4444);
    check_all("ce masked");
    // unmask CE only, junk bits ignored
    wr(8'h0C, 32'hFFFF_FF7F); m_mask = 2'b10;
    check_all("ce unmasked");
    // second CE leaves the log frozen
    evt(2'b01, 1'b0, 32'h0, 18'h3FFFF, 64'hDEAD_BEEF_0000_0001);
    check_all("R4 frozen");
    // clear and new CE in the same cycle: new event wins
    evt(2'b01, 1'b1, 32'h0000_0040, 18'h00ABC, 64'h0123_4567_89AB_CDEF);
    check_all("R3 collide");
    // clear alone, then rearmed capture
    wr(8'h04, 32'h0000_0040); m_flag[0] = 1'b0;
    check_all("R2 cleared");
    wr(8'h04, 32'hFFFF_FF3F);
    check_all("R2 zero write");
    evt(2'b01, 1'b0, 32'h0, 18'h00777, 64'hCAFE_F00D_5555_AAAA);
    check_all("R4 rearm");
    // both classes in one cycle
    wr(8'h0C, 32'h0000_0080); m_mask = 2'b00;
    wr(8'h04, 32'h0000_00C0); m_flag = 2'b00;
    evt(2'b11, 1'b0, 32'h0, 18'h01F00, 64'hA5A5_A5A5_5A5A_5A5A);
    check_all("R5 both");
    wr(8'h10, 32'h0000_00C0); m_mask = 2'b11;
    check_all("R6 maskset");

    // injection: count register width
    wr(8'h34, 32'hAB00_0002);
    rd(8'h34, d); chk("R9 count truncated", d, 32'h0000_0002);
    wr(8'h2C, 32'h0000_0020);
    wr(8'h30, 32'h0000_0000);
    rd(8'h2C, d); chk("R9 pattern lo", d, 32'h0000_0020);
    memw(f); chk("R10 write 1 not flipped", f, 64'h0);
    memw(f); chk("R10 write 2 not flipped", f, 64'h0);
    rd(8'h34, d); chk("R10 count at zero", d, 32'h0);
    memw(f); chk("R10 write 3 flipped", f, 64'h20);
    rd(8'h2C, d); chk("R10 pattern lo cleared", d, 32'h0);
    memw(f); chk("R10 one shot", f, 64'h0);
    // two-bit pattern armed with count 0
    wr(8'h2C, 32'h0000_0008);
    wr(8'h30, 32'h0000_0001);
    rd(8'h30, d); chk("R9 pattern hi", d, 32'h1);
    repeat (2) @(negedge clk);
    #1; chk("R11 no flip without write", inj_flip, 64'h0);
    memw(f); chk("R10 double-bit flip", f, 64'h0000_0001_0000_0008);
    rd(8'h30, d); chk("R10 pattern hi cleared", d, 32'h0);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int unsigned op;
      logic [31:0] w;
      op = $urandom % 4;
      w  = $urandom;
      case (op)
        0: evt(2'($urandom), 1'b0, 32'h0, AW'($urandom), {$urandom, $urandom});
        1: evt(2'b00, 1'b1, w, '0, 64'h0);
        2: evt(2'($urandom), 1'b1, w, AW'($urandom), {$urandom, $urandom});
        default: begin
          if ($urandom % 2 == 0) begin
            wr(8'h0C, w); m_mask = m_mask & ~w[7:6];
          end else begin
            wr(8'h10, w); m_mask = m_mask | w[7:6];
          end
        end
      endcase
      check_all("R3 random");
    end

    finish_run();
  end
endmodule